// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counter Bank

This block keeps per-frame event counts for a gigabit Ethernet MAC. At the end of every received frame the receive path presents a one-cycle status summary. It gives the frame length in bytes, whether the frame check sequence failed, and whether the frame ended on a partial octet. It also flags an invalid codeword seen outside a collision, a receive FIFO overflow, and the type field and control opcode. The transmit path presents a similar summary with the length, a FIFO underflow flag and a pause-frame flag. The block sorts each frame into error and control classes and bumps the matching counters.

Each counter is 32 bits wide by default and saturates instead of wrapping. Software reads the counters through a 16-bit read port addressed by an 8-bit register number. Each counter occupies two adjacent addresses. Reading the low half snapshots the upper half, so the pair reads back coherently while the counter keeps running. The maximum legal length is chosen separately for receive and transmit by two select inputs. A synchronous clear input zeroes the whole bank.

Top module: `mac_stat_bank`

## Requirements
- R1: A frame is length-legal when 64 <= length <= limit. The length excludes the preamble. The limit comes from the 2-bit select of that direction: 00 gives 1518, 01 gives 1522, 10 gives 1535, and 11 sets no upper limit. Select 00 is the default.
- R2: A received frame with a failed check sequence counts as a CRC error (counter at 0xEC/0xED) when it holds a whole number of octets. If it ends on a partial octet, it counts as an alignment error instead (counter at 0xEE/0xEF).
- R3: The symbol-error counter at 0xE2/0xE3 rises by at most one per received frame. It counts only frames whose symbol flag is set while the collision flag is clear.
- R4: The bad-receive counter at 0xEA/0xEB counts a received frame if any of these hold: it is not length-legal, it has a CRC error, it overflowed the receive FIFO, or it has a counted symbol error. An alignment error alone does not make the frame bad.
- R5: The bad-transmit counter at 0xF0/0xF1 counts a transmitted frame that is not length-legal or that underflowed the transmit FIFO.
- R6: A received frame is a valid control frame when it is not bad, its check sequence passed and its type field is 0x8808. A valid control frame with opcode 0x0001 counts at 0xE8/0xE9 (pause received). Any other opcode counts at 0xE4/0xE5 (unsupported opcode).
- R7: A transmitted frame marked as pause counts at 0xE6/0xE7, but only when it is not a bad transmit frame.
- R8: The even address of a pair returns counter bits 15:0 and stores bits 31:16 in a shadow. The odd address returns that shadow, so the value is the one taken at the last low-half read.
- R9: A counter that holds all ones stays all ones on further events. The default width is 32 bits.
- R10: A one-cycle clear zeroes every counter and the shadow. Counting resumes on the following events.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. Addresses outside 0xE2..0xF1 return 0.
- R12: After reset all counters, the shadow and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of all counters and the shadow |
| rx_max_sel | input | 2 | Receive length-limit select |
| tx_max_sel | input | 2 | Transmit length-limit select |
| rx_done | input | 1 | One-cycle strobe, receive status valid |
| rx_bytes | input | 16 | Received frame length in bytes |
| rx_fcs_bad | input | 1 | Check sequence failed |
| rx_dribble | input | 1 | Frame ended on a partial octet |
| rx_sym_err | input | 1 | One or more invalid codewords in the frame |
| rx_in_coll | input | 1 | The symbol errors occurred during a collision |
| rx_fifo_ovf | input | 1 | Receive FIFO overflowed |
| rx_etype | input | 16 | Type field of the frame |
| rx_opcode | input | 16 | Control opcode of the frame |
| tx_done | input | 1 | One-cycle strobe, transmit status valid |
| tx_bytes | input | 16 | Transmitted frame length in bytes |
| tx_fifo_unf | input | 1 | Transmit FIFO underflowed |
| tx_is_pause | input | 1 | Frame was a pause frame |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Register number |
| reg_rdata | output | 16 | Read data, registered |

## Verification
The assertions assume that each status strobe describes one complete frame, so a counter can move by at most one per cycle. They also assume that the status flags are meaningful only while the strobe is high. The bench drives every flag and field only inside a strobed cycle and returns them to zero afterwards. It issues reads only between frame events, so each expected value is fixed when the read is queued. To keep saturation within reach, the bench builds the bank with 17-bit counters. The upper half then carries a single live bit, which still exercises the shadow path.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    localparam int NUM_CTR = 8;

    // counter slots, slot i lives at BASE_ADDR + 2*i
    localparam int CTR_SYM     = 0;
    localparam int CTR_UNSUP   = 1;
    localparam int CTR_TXPAUSE = 2;
    localparam int CTR_RXPAUSE = 3;
    localparam int CTR_RXBAD   = 4;
    localparam int CTR_CRC     = 5;
    localparam int CTR_ALIGN   = 6;
    localparam int CTR_TXBAD   = 7;

    localparam logic [7:0]  BASE_ADDR = 8'hE2;
    localparam logic [15:0] LEN_MIN   = 16'd64;
    localparam logic [15:0] CTRL_TYPE = 16'h8808;
    localparam logic [15:0] PAUSE_OP  = 16'h0001;

    typedef struct packed {
        logic        vld;
        logic [15:0] len;
        logic        fcs_bad;
        logic        dribble;
        logic        sym_err;
        logic        in_coll;
        logic        ovf;
        logic [15:0] etype;
        logic [15:0] opcode;
    } rx_stat_t;

    typedef struct packed {
        logic        vld;
        logic [15:0] len;
        logic        unf;
        logic        pause;
    } tx_stat_t;

    function automatic logic len_legal(input logic [15:0] len, input logic [1:0] sel);
        logic [15:0] lim;
        case (sel)
            2'd0:    lim = 16'd1518;
            2'd1:    lim = 16'd1522;
            2'd2:    lim = 16'd1535;
            default: lim = 16'hFFFF;
        endcase
        return (len >= LEN_MIN) && ((sel == 2'd3) || (len <= lim));
    endfunction

endpackage

// File: rtl/mac_stat_classify.sv
module mac_stat_classify
    import mac_stat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  rx_stat_t           rx,
    input  tx_stat_t           tx,
    input  logic [1:0]         rx_max_sel,
    input  logic [1:0]         tx_max_sel,
    output logic [NUM_CTR-1:0] inc
);

    logic rx_len_ok, tx_len_ok, crc_err, aln_err, sym_cnt, rx_bad, tx_bad, ctrl_ok;

    always_comb begin
        rx_len_ok = len_legal(rx.len, rx_max_sel);
        tx_len_ok = len_legal(tx.len, tx_max_sel);
        crc_err   = rx.fcs_bad && !rx.dribble;
        aln_err   = rx.fcs_bad &&  rx.dribble;
        sym_cnt   = rx.sym_err && !rx.in_coll;
        rx_bad    = !rx_len_ok || crc_err || rx.ovf || sym_cnt;
        tx_bad    = !tx_len_ok || tx.unf;
        ctrl_ok   = !rx_bad && !rx.fcs_bad && (rx.etype == CTRL_TYPE);

        inc               = '0;
        inc[CTR_SYM]      = rx.vld && sym_cnt;
        inc[CTR_CRC]      = rx.vld && crc_err;
        inc[CTR_ALIGN]    = rx.vld && aln_err;
        inc[CTR_RXBAD]    = rx.vld && rx_bad;
        inc[CTR_RXPAUSE]  = rx.vld && ctrl_ok && (rx.opcode == PAUSE_OP);
        inc[CTR_UNSUP]    = rx.vld && ctrl_ok && (rx.opcode != PAUSE_OP);
        inc[CTR_TXBAD]    = tx.vld && tx_bad;
        inc[CTR_TXPAUSE]  = tx.vld && tx.pause && !tx_bad;
    end

    // R2
    fcs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx.fcs_bad |-> !inc[CTR_CRC] && !inc[CTR_ALIGN]);

    // R6
    pause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc[CTR_RXPAUSE] |-> rx.etype == CTRL_TYPE && rx.opcode == PAUSE_OP
                             && !inc[CTR_RXBAD] && !inc[CTR_UNSUP]);

endmodule

// File: rtl/mac_stat_ctr.sv
module mac_stat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (inc && (st_q.cnt != '1))
            st_d.cnt = st_q.cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '1 && !clr) |=> st_q.cnt == '1);

    // R10
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.cnt == '0);

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + W'(1)));

endmodule

// File: rtl/mac_stat_readout.sv
module mac_stat_readout
    import mac_stat_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           rd,
    input  logic [7:0]     addr,
    input  logic [N*W-1:0] cnt_flat,
    output logic [15:0]    rdata
);

    localparam logic [7:0] SPAN = 8'(2 * N);

    typedef struct packed {
        logic [15:0] rdata;
        logic [15:0] shadow;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [7:0]  offset;
    logic        mapped;
    logic [31:0] sel_val;

    always_comb begin
        offset  = addr - BASE_ADDR;
        mapped  = (addr >= BASE_ADDR) && (offset < SPAN);
        sel_val = '0;
        for (int i = 0; i < N; i++) begin
            if (offset[7:1] == 7'(i))
                sel_val = 32'(cnt_flat[i*W +: W]);
        end

        st_d = st_q;
        if (clr)
            st_d.shadow = '0;
        if (rd) begin
            if (!mapped) begin
                st_d.rdata = '0;
            end else if (!offset[0]) begin
                st_d.rdata = sel_val[15:0];
                if (!clr)
                    st_d.shadow = sel_val[31:16];
            end else begin
                st_d.rdata = st_q.shadow;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (addr < BASE_ADDR || addr >= BASE_ADDR + SPAN)) |=> rdata == 16'h0000);

    // R11
    hold_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [1:0]  rx_max_sel,
    input  logic [1:0]  tx_max_sel,
    input  logic        rx_done,
    input  logic [15:0] rx_bytes,
    input  logic        rx_fcs_bad,
    input  logic        rx_dribble,
    input  logic        rx_sym_err,
    input  logic        rx_in_coll,
    input  logic        rx_fifo_ovf,
    input  logic [15:0] rx_etype,
    input  logic [15:0] rx_opcode,
    input  logic        tx_done,
    input  logic [15:0] tx_bytes,
    input  logic        tx_fifo_unf,
    input  logic        tx_is_pause,
    input  logic        reg_rd,
    input  logic [7:0]  reg_addr,
    output logic [15:0] reg_rdata
);

    rx_stat_t rx_s;
    tx_stat_t tx_s;
    logic [NUM_CTR-1:0]       inc;
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;

    assign rx_s = '{vld: rx_done, len: rx_bytes, fcs_bad: rx_fcs_bad, dribble: rx_dribble,
                    sym_err: rx_sym_err, in_coll: rx_in_coll, ovf: rx_fifo_ovf,
                    etype: rx_etype, opcode: rx_opcode};
    assign tx_s = '{vld: tx_done, len: tx_bytes, unf: tx_fifo_unf, pause: tx_is_pause};

    mac_stat_classify u_cls (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx         (rx_s),
        .tx         (tx_s),
        .rx_max_sel (rx_max_sel),
        .tx_max_sel (tx_max_sel),
        .inc        (inc)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        mac_stat_ctr #(.W(CTR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[g]),
            .cnt   (cnt_flat[g*CTR_W +: CTR_W])
        );
    end

    mac_stat_readout #(.N(NUM_CTR), .W(CTR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .cnt_flat (cnt_flat),
        .rdata    (reg_rdata)
    );

endmodule

// File: tb/sim_mac_stat_bank.sv
module sim_mac_stat_bank;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 17;
    localparam int WDOG       = 190000;
    localparam logic [31:0] MAXV = (32'd1 << CW) - 32'd1;

    logic        clk = 0, rst_n = 0, clr = 0;
    logic [1:0]  rx_max_sel = 0, tx_max_sel = 0;
    logic        rx_done = 0, rx_fcs_bad = 0, rx_dribble = 0, rx_sym_err = 0;
    logic        rx_in_coll = 0, rx_fifo_ovf = 0;
    logic [15:0] rx_bytes = 0, rx_etype = 0, rx_opcode = 0;
    logic        tx_done = 0, tx_fifo_unf = 0, tx_is_pause = 0;
    logic [15:0] tx_bytes = 0;
    logic        reg_rd = 0;
    logic [7:0]  reg_addr = 0;
    logic [15:0] reg_rdata;

    mac_stat_bank #(.CTR_W(CW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int unsigned m [8];
    logic [15:0] shadow_m = 0;
    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] q_exp [$];
    string       q_tag [$];
    logic        rd_seen = 0;

    function automatic logic len_ok(input int len, input logic [1:0] sel);
        int lim;
        lim = (sel == 0) ? 1518 : (sel == 1) ? 1522 : 1535;
        return len >= 64 && (sel == 3 || len <= lim);
    endfunction

    function automatic void bump(input int i);
        if (m[i] != MAXV) m[i]++;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data one cycle after each strobe
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        cyc++;
        if (rd_seen) begin
            if (q_exp.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11: unexpected read data %h", reg_rdata);
            end else begin
                check(q_tag.pop_front(), reg_rdata, q_exp.pop_front());
            end
        end
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog: run hung");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic rd(input logic [7:0] a, input string tag);
        logic [15:0] e;
        int off;
        off = int'(a) - 'hE2;
        if (off < 0 || off >= 16) e = 0;
        else if (off % 2 == 0) begin
            e = m[off/2][15:0];
            shadow_m = m[off/2][31:16];
        end else e = shadow_m;
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rxf(input int len, input logic fcs, input logic drib, input logic sym,
                       input logic coll, input logic ovf, input logic [15:0] typ,
                       input logic [15:0] op);
        logic crc, aln, sc, bad;
        crc = fcs && !drib; aln = fcs && drib; sc = sym && !coll;
        bad = !len_ok(len, rx_max_sel) || crc || ovf || sc;
        if (sc) bump(0);
        if (crc) bump(5);
        if (aln) bump(6);
        if (bad) bump(4);
        if (!bad && !fcs && typ == 16'h8808) bump(op == 16'h0001 ? 3 : 1);
        @(negedge clk);
        rx_done = 1; rx_bytes = 16'(len); rx_fcs_bad = fcs; rx_dribble = drib;
        rx_sym_err = sym; rx_in_coll = coll; rx_fifo_ovf = ovf; rx_etype = typ; rx_opcode = op;
        @(negedge clk);
        rx_done = 0; rx_bytes = 0; rx_fcs_bad = 0; rx_dribble = 0; rx_sym_err = 0;
        rx_in_coll = 0; rx_fifo_ovf = 0; rx_etype = 0; rx_opcode = 0;
    endtask

    task automatic txf(input int len, input logic unf, input logic pse, input int n);
        logic bad;
        bad = !len_ok(len, tx_max_sel) || unf;
        for (int k = 0; k < n; k++) begin
            if (bad) bump(7);
            if (pse && !bad) bump(2);
        end
        @(negedge clk);
        tx_done = 1; tx_bytes = 16'(len); tx_fifo_unf = unf; tx_is_pause = pse;
        repeat (n) @(negedge clk);
        tx_done = 0; tx_bytes = 0; tx_fifo_unf = 0; tx_is_pause = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 rdata after reset", reg_rdata, 16'h0000);
        rd(8'hEA, "R12 rx bad lo after reset");
        rd(8'hE2, "R12 symbol lo after reset");

        // R1 length limits per select
        rx_max_sel = 0;
        rxf(63, 0,0,0,0,0, 0, 0); rxf(64, 0,0,0,0,0, 0, 0);
        rxf(1518, 0,0,0,0,0, 0, 0); rxf(1519, 0,0,0,0,0, 0, 0);
        rx_max_sel = 1; rxf(1522, 0,0,0,0,0, 0, 0); rxf(1523, 0,0,0,0,0, 0, 0);
        rx_max_sel = 2; rxf(1535, 0,0,0,0,0, 0, 0); rxf(1536, 0,0,0,0,0, 0, 0);
        rx_max_sel = 3; rxf(9000, 0,0,0,0,0, 0, 0); rxf(40, 0,0,0,0,0, 0, 0);
        rx_max_sel = 0;
        rd(8'hEA, "R1 rx bad lo after length sweep");
        rd(8'hEB, "R1 rx bad hi after length sweep");

        // R2 crc versus alignment
        rxf(100, 1,0,0,0,0, 0, 0); rxf(100, 1,0,0,0,0, 0, 0);
        rxf(101, 1,1,0,0,0, 0, 0); rxf(101, 1,1,0,0,0, 0, 0); rxf(101, 1,1,0,0,0, 0, 0);
        rd(8'hEC, "R2 crc count");
        rd(8'hEE, "R2 alignment count");

        // R3 symbol errors, R4 bad receive
        rxf(200, 0,0,1,0,0, 0, 0);
        rxf(200, 0,0,1,1,0, 0, 0);
        rd(8'hE2, "R3 symbol count once, collision excluded");
        rxf(200, 0,0,0,0,1, 0, 0);
        rd(8'hEA, "R4 rx bad with overflow/symbol/crc");

        // R6 control frames
        rxf(64, 0,0,0,0,0, 16'h8808, 16'h0001);
        rxf(64, 0,0,0,0,0, 16'h8808, 16'h0002);
        rxf(64, 1,0,0,0,0, 16'h8808, 16'h0001);
        rxf(64, 0,0,0,0,0, 16'h0800, 16'h0001);
        rxf(63, 0,0,0,0,0, 16'h8808, 16'h0001);
        rd(8'hE8, "R6 pause received");
        rd(8'hE4, "R6 unsupported opcode");

        // R5 / R7 transmit
        tx_max_sel = 0; txf(63, 0, 0, 1); txf(1519, 0, 0, 1);
        tx_max_sel = 1; txf(1520, 0, 0, 1); tx_max_sel = 0;
        txf(500, 1, 0, 1); txf(64, 0, 1, 1); txf(64, 1, 1, 1);
        rd(8'hF0, "R5 tx bad");
        rd(8'hE6, "R7 tx pause");

        // R11 unmapped
        rd(8'hE1, "R11 below range"); rd(8'hF2, "R11 above range"); rd(8'h00, "R11 address zero");

        // R8 shadow coherence, R9 saturation
        txf(64, 0, 1, 32'h0000FFFF - int'(m[2]));
        rd(8'hE6, "R8 low half at 0xFFFF");
        txf(64, 0, 1, 1);
        rd(8'hE7, "R8 high half from shadow, not live");
        rd(8'hE6, "R8 low half after carry");
        rd(8'hE7, "R8 high half after carry");
        txf(64, 0, 1, int'(MAXV) - int'(m[2]) + 5);
        rd(8'hE6, "R9 saturated low");
        rd(8'hE7, "R9 saturated high");

        // R10 clear
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        for (int i = 0; i < 8; i++) m[i] = 0;
        shadow_m = 0;
        rd(8'hE7, "R10 shadow cleared");
        rd(8'hE6, "R10 tx pause cleared");
        rd(8'hEA, "R10 rx bad cleared");
        rxf(300, 0,0,1,0,0, 0, 0);
        rd(8'hE2, "R10 counting resumes");

        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11: %0d reads got no data, expected 0", q_exp.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule